// File: doc/BRIEF.md
# Four-Direction Symmetric Co-occurrence Accumulator

This block builds four gray-level co-occurrence matrices from one pass over a grayscale frame. The frame arrives in raster order, one pixel per accepted beat. Each pixel is paired with up to four pixels already received: the one to its left, the one above, the one above and to the right, and the one above and to the left. These four relations are the horizontal (0°), rising-diagonal (45°), vertical (90°) and falling-diagonal (135°) directions, each at a distance of one pixel. Every pair is counted symmetrically into its own direction's matrix, so a pair of values (a,b) adds one to bin (a,b) and one to bin (b,a).

A pixel tagged as start of frame clears all four matrices and is taken as position (0,0). After the last pixel of the frame, the block stops taking pixels and sends every count word of all four matrices on an output stream, with a last marker on the final word. It then takes pixels again. Image width, height, pixel width and counter width are parameters. Small values can therefore be used in verification, while the same code covers a 128x128, 8-bit, 16-bit-count setup.

Top module: `glcm4_accum`

## Requirements
- R1: The 0° matrix counts pairs made of a pixel and its left neighbour in the same row. Each pair adds 1 to bin (p,q) and 1 to bin (q,p), so a pair of equal values adds 2 to its diagonal bin. For the 4x4 image with rows 0 0 1 2 / 0 1 3 2 / 0 2 3 2 / 1 2 3 0, bin (2,3) is 4.
- R2: The 90° matrix counts, with the same symmetric rule, pairs made of a pixel and the pixel directly above it.
- R3: The 45° matrix counts, symmetrically, pairs made of a pixel and the pixel one row up and one column right. For the R1 image, bin (2,3) is 5.
- R4: The 135° matrix counts, symmetrically, pairs made of a pixel and the pixel one row up and one column left.
- R5: A neighbour outside the image gives no pair. A W x H frame therefore adds 2*H*(W-1) to the 0° matrix in total, 2*(H-1)*W to the 90° matrix, and 2*(H-1)*(W-1) to each diagonal matrix.
- R6: An accepted pixel with pix_sof high clears every bin of all four matrices and is placed at row 0, column 0. Pixels before it have no effect on the following frame.
- R7: A bin that would go past 2^CNT_W-1 stays at 2^CNT_W-1.
- R8: After W*H pixels are accepted, the block sends 4*L*L words (L = 2^PIX_W). Word index k = d*L*L + i*L + j carries bin (i,j) of direction d, with d = 0,1,2,3 for 0°, 45°, 90° and 135°. out_last is high only on word k = 4*L*L-1, and out_valid is low in the cycle after that word is taken.
- R9: pix_ready is low while words are being sent. Pixels offered during that time, including ones with pix_sof high, change no count.
- R10: While out_valid is high and out_ready is low, out_valid, out_data and out_last keep their values.
- R11: After reset, pix_ready is high and out_valid and out_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Pixel beat offered |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| pix_sof | input | 1 | Offered pixel is the first of a frame |
| pix_data | input | PIX_W | Gray level of the offered pixel |
| out_valid | output | 1 | Count word offered |
| out_ready | input | 1 | Sink takes the count word |
| out_data | output | CNT_W | Count word |
| out_last | output | 1 | Final word of the readout |

## Verification
The matrices are tried with four frames. A textured image with a known result separates the four directions, because each direction gives different bin values. A ramp that is constant along one diagonal puts all 45° counts on the matrix diagonal and keeps them off the 135° diagonal, and its per-direction totals show how edge pixels are handled. A flat frame drives the diagonal bins into saturation. A checkerboard, sent with idle gaps between pixels, keeps the 0° and 90° counts off the diagonal while the diagonal directions land on it. One readout is stalled from the sink side to check that the output holds, another is sent while pixels with start-of-frame are offered, and an aborted partial frame is followed by a full one to show that clearing works.

// File: rtl/glcm_pkg.sv
package glcm_pkg;
   localparam int unsigned NDIR = 4;

   typedef enum logic [1:0] {
      DIR_0   = 2'd0,
      DIR_45  = 2'd1,
      DIR_90  = 2'd2,
      DIR_135 = 2'd3
   } dir_e;

   typedef enum logic {
      PH_ACCUM = 1'b0,
      PH_DUMP  = 1'b1
   } phase_e;
endpackage

// File: rtl/glcm_nbr.sv
// Raster position tracking and neighbour window: one row of history plus
// the previous pixel and the previous pixel's upper neighbour.
module glcm_nbr
   import glcm_pkg::*;
#(
   parameter int unsigned IMG_W = 8,
   parameter int unsigned IMG_H = 8,
   parameter int unsigned PIX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             sof,
   input  logic [PIX_W-1:0] pix,
   output logic [PIX_W-1:0] nb_pix [NDIR],
   output logic [NDIR-1:0]  nb_ok,
   output logic             frame_end
);
   localparam int unsigned COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
   localparam int unsigned ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1;
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

   logic [PIX_W-1:0] line_q [IMG_W];
   logic [PIX_W-1:0] left_q, ul_q;
   logic [COL_W-1:0] col_q, cur_col, ur_col;
   logic [ROW_W-1:0] row_q, cur_row;
   logic             at_l, at_r, at_top, at_bot;

   always_comb begin
      cur_col = sof ? '0 : col_q;
      cur_row = sof ? '0 : row_q;
      at_l    = (cur_col == '0);
      at_r    = (cur_col == COL_LAST);
      at_top  = (cur_row == '0);
      at_bot  = (cur_row == ROW_LAST);
      ur_col  = at_r ? '0 : cur_col + 1'b1;

      nb_pix[DIR_0]   = left_q;
      nb_ok[DIR_0]    = !at_l;
      nb_pix[DIR_45]  = line_q[ur_col];
      nb_ok[DIR_45]   = !at_top && !at_r;
      nb_pix[DIR_90]  = line_q[cur_col];
      nb_ok[DIR_90]   = !at_top;
      nb_pix[DIR_135] = ul_q;
      nb_ok[DIR_135]  = !at_top && !at_l;

      frame_end = at_r && at_bot;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         left_q <= '0;
         ul_q   <= '0;
         for (int c = 0; c < int'(IMG_W); c++) line_q[c] <= '0;
      end else if (take) begin
         line_q[cur_col] <= pix;
         left_q          <= pix;
         ul_q            <= line_q[cur_col];
         if (at_r) begin
            col_q <= '0;
            row_q <= at_bot ? '0 : cur_row + 1'b1;
         end else begin
            col_q <= cur_col + 1'b1;
            row_q <= cur_row;
         end
      end
   end
endmodule

// File: rtl/glcm_bank.sv
// One direction's matrix: L*L saturating counters, two symmetric bumps per pair.
module glcm_bank #(
   parameter int unsigned PIX_W = 3,
   parameter int unsigned CNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               bump,
   input  logic [PIX_W-1:0]   pa,
   input  logic [PIX_W-1:0]   pb,
   input  logic [2*PIX_W-1:0] rd_bin,
   output logic [CNT_W-1:0]   rd_cnt
);
   localparam int unsigned BIN_W = 2 * PIX_W;
   localparam int unsigned BINS  = 1 << BIN_W;

   logic [CNT_W-1:0] cnt_q [BINS];
   logic [CNT_W-1:0] nxt   [BINS];
   logic [BIN_W-1:0] bin_a, bin_b;

   assign bin_a  = {pa, pb};
   assign bin_b  = {pb, pa};
   assign rd_cnt = cnt_q[rd_bin];

   always_comb begin
      for (int b = 0; b < int'(BINS); b++) begin
         logic [1:0]       add;
         logic [CNT_W:0]   wide;
         add  = {1'b0, bin_a == BIN_W'(b)} + {1'b0, bin_b == BIN_W'(b)};
         wide = {1'b0, cnt_q[b]} + (CNT_W+1)'(add);
         nxt[b] = wide[CNT_W] ? '1 : wide[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int b = 0; b < int'(BINS); b++) cnt_q[b] <= '0;
      end else if (clear) begin
         for (int b = 0; b < int'(BINS); b++) cnt_q[b] <= '0;
      end else if (bump) begin
         for (int b = 0; b < int'(BINS); b++) cnt_q[b] <= nxt[b];
      end
   end
endmodule

// File: rtl/glcm_dump.sv
// Readout sequencer: walks direction-major, then bin index in row-major order.
module glcm_dump
   import glcm_pkg::*;
#(
   parameter int unsigned BIN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             out_ready,
   output logic             dumping,
   output logic             out_last,
   output logic [1:0]       rd_dir,
   output logic [BIN_W-1:0] rd_bin
);
   localparam logic [BIN_W-1:0] BIN_END = '1;
   localparam logic [1:0]       DIR_END = 2'(NDIR - 1);

   phase_e ph_q;

   assign dumping  = (ph_q == PH_DUMP);
   assign out_last = dumping && (rd_dir == DIR_END) && (rd_bin == BIN_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_ACCUM;
         rd_dir <= '0;
         rd_bin <= '0;
      end else if (ph_q == PH_ACCUM) begin
         if (start) begin
            ph_q   <= PH_DUMP;
            rd_dir <= '0;
            rd_bin <= '0;
         end
      end else if (out_ready) begin
         if (out_last) begin
            ph_q <= PH_ACCUM;
         end else if (rd_bin == BIN_END) begin
            rd_bin <= '0;
            rd_dir <= rd_dir + 1'b1;
         end else begin
            rd_bin <= rd_bin + 1'b1;
         end
      end
   end
endmodule

// File: rtl/glcm4_accum.sv
module glcm4_accum
   import glcm_pkg::*;
#(
   parameter int unsigned IMG_W = 8,
   parameter int unsigned IMG_H = 8,
   parameter int unsigned PIX_W = 3,
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_valid,
   output logic             pix_ready,
   input  logic             pix_sof,
   input  logic [PIX_W-1:0] pix_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [CNT_W-1:0] out_data,
   output logic             out_last
);
   localparam int unsigned BIN_W = 2 * PIX_W;

   initial begin : p_param_chk
      if (IMG_W < 2) $error("IMG_W must be at least 2");
      if (IMG_H < 2) $error("IMG_H must be at least 2");
      if (PIX_W < 1 || PIX_W > 8) $error("PIX_W must be 1..8");
      if (CNT_W < 2) $error("CNT_W must be at least 2");
   end

   logic             take, frame_end, dumping;
   logic [PIX_W-1:0] nb_pix [NDIR];
   logic [NDIR-1:0]  nb_ok;
   logic [1:0]       rd_dir;
   logic [BIN_W-1:0] rd_bin;
   logic [CNT_W-1:0] rd_cnt [NDIR];

   assign pix_ready = !dumping;
   assign take      = pix_valid && pix_ready;
   assign out_valid = dumping;
   assign out_data  = rd_cnt[rd_dir];

   glcm_nbr #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) u_nbr (
      .clk(clk), .rst_n(rst_n), .take(take), .sof(pix_sof), .pix(pix_data),
      .nb_pix(nb_pix), .nb_ok(nb_ok), .frame_end(frame_end)
   );

   for (genvar d = 0; d < int'(NDIR); d++) begin : g_dir
      glcm_bank #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .clear(take && pix_sof),
         .bump(take && nb_ok[d]),
         .pa(pix_data), .pb(nb_pix[d]),
         .rd_bin(rd_bin), .rd_cnt(rd_cnt[d])
      );
   end

   glcm_dump #(.BIN_W(BIN_W)) u_dump (
      .clk(clk), .rst_n(rst_n), .start(take && frame_end),
      .out_ready(out_ready), .dumping(dumping), .out_last(out_last),
      .rd_dir(rd_dir), .rd_bin(rd_bin)
   );
endmodule

// File: rtl/glcm4_accum_chk.sv
module glcm4_accum_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_valid,
   input logic             pix_ready,
   input logic             pix_sof,
   input logic             out_valid,
   input logic             out_ready,
   input logic [CNT_W-1:0] out_data,
   input logic             out_last
);
   a_r9_no_take_in_dump: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !pix_ready);

   a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

   a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   a_r6_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && pix_ready && pix_sof) |=> !out_valid);
endmodule

bind glcm4_accum glcm4_accum_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
   .pix_sof(pix_sof), .out_valid(out_valid), .out_ready(out_ready),
   .out_data(out_data), .out_last(out_last)
);

// File: tb/glcm4_accum_test.sv
`timescale 1ns/1ps
module glcm4_accum_test;
   localparam int W = 4, H = 4, PW = 2, CW = 4;
   localparam int L = 1 << PW, NB = L * L, NW = 4 * NB, NP = W * H;
   localparam int CMAX = (1 << CW) - 1;

   // frames: 0 textured, 1 flat, 2 diagonal ramp, 3 checkerboard
   localparam logic [1:0] FRAMES [4][16] = '{
      '{0,0,1,2, 0,1,3,2, 0,2,3,2, 1,2,3,0},
      '{0,0,0,0, 0,0,0,0, 0,0,0,0, 0,0,0,0},
      '{0,1,2,3, 1,2,3,0, 2,3,0,1, 3,0,1,2},
      '{3,0,3,0, 0,3,0,3, 3,0,3,0, 0,3,0,3}
   };
   localparam string DREQ [4] = '{"R1", "R3", "R2", "R4"};

   logic clk = 1'b0, rst_n = 1'b0;
   logic pix_valid = 1'b0, pix_sof = 1'b0, out_ready = 1'b1;
   logic [PW-1:0] pix_data = '0;
   logic pix_ready, out_valid, out_last;
   logic [CW-1:0] out_data;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int exp_q [4][NB];
   int got   [4][NB];

   always #2.5 clk = ~clk;

   glcm4_accum #(.IMG_W(W), .IMG_H(H), .PIX_W(PW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .pix_sof(pix_sof), .pix_data(pix_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic build(input int f);
      for (int d = 0; d < 4; d++) for (int b = 0; b < NB; b++) exp_q[d][b] = 0;
      for (int r = 0; r < H; r++) begin
         for (int c = 0; c < W; c++) begin
            int p;
            p = FRAMES[f][r*W+c];
            for (int d = 0; d < 4; d++) begin
               int rr, cc;
               rr = (d == 0) ? r : r - 1;
               cc = (d == 0) ? c - 1 : (d == 1) ? c + 1 : (d == 2) ? c : c - 1;
               if (rr >= 0 && cc >= 0 && cc < W) begin
                  int q;
                  q = FRAMES[f][rr*W+cc];
                  exp_q[d][p*L+q]++;
                  exp_q[d][q*L+p]++;
               end
            end
         end
      end
      for (int d = 0; d < 4; d++)
         for (int b = 0; b < NB; b++) if (exp_q[d][b] > CMAX) exp_q[d][b] = CMAX;
   endtask

   task automatic send(input int f, input int npix, input bit gap);
      for (int k = 0; k < npix; k++) begin
         @(negedge clk);
         pix_valid = 1'b1;
         pix_data  = FRAMES[f][k];
         pix_sof   = (k == 0);
         @(posedge clk);
         if (gap && k < npix - 1) begin
            @(negedge clk);
            pix_valid = 1'b0;
            @(posedge clk);
         end
      end
   endtask

   task automatic collect(input int stall_at, input bit poke, output int mism);
      int k;
      k = 0;
      mism = 0;
      while (k < NW) begin
         @(negedge clk);
         pix_valid = poke && (k < NW - 1);
         pix_sof   = poke && (k < NW - 1);
         pix_data  = '1;
         if (out_valid) begin
            int e;
            e = exp_q[k/NB][k%NB];
            got[k/NB][k%NB] = out_data;
            if (int'(out_data) != e) mism++;
            chk(int'(out_data) == e, DREQ[k/NB], out_data, e);
            chk(out_last == (k == NW - 1), "R8", out_last, k == NW - 1);
            chk(!pix_ready, "R9", pix_ready, 0);
            if (k == stall_at) begin
               out_ready = 1'b0;
               repeat (3) begin
                  @(negedge clk);
                  chk(out_valid && int'(out_data) == e, "R10", out_data, e);
               end
               out_ready = 1'b1;
            end
            k++;
         end
      end
      @(negedge clk);
      pix_valid = 1'b0;
      pix_sof   = 1'b0;
      chk(!out_valid, "R8", out_valid, 0);
   endtask

   function automatic int dsum(input int d);
      int s;
      s = 0;
      for (int b = 0; b < NB; b++) s += got[d][b];
      return s;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      int mm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pix_ready == 1'b1, "R11", pix_ready, 1);
      chk(out_valid == 1'b0, "R11", out_valid, 0);
      chk(out_last == 1'b0, "R11", out_last, 0);

      for (int f = 0; f < 4; f++) begin
         build(f);
         send(f, NP, f == 3);
         collect((f == 2) ? 5 : -1, f == 1, mm);
         chk(mm == 0, (f == 1) ? "R9" : "R5", mm, 0);
         if (f == 0) begin
            chk(got[0][2*L+3] == 4, "R1", got[0][2*L+3], 4);
            chk(got[1][2*L+3] == 5, "R3", got[1][2*L+3], 5);
         end
         if (f == 1) chk(got[0][0] == CMAX, "R7", got[0][0], CMAX);
         if (f == 2) begin
            chk(dsum(0) == 2*H*(W-1), "R5", dsum(0), 2*H*(W-1));
            chk(dsum(1) == 2*(H-1)*(W-1), "R5", dsum(1), 2*(H-1)*(W-1));
            chk(dsum(2) == 2*(H-1)*W, "R5", dsum(2), 2*(H-1)*W);
            chk(dsum(3) == 2*(H-1)*(W-1), "R5", dsum(3), 2*(H-1)*(W-1));
         end
         chk(pix_ready == 1'b1, "R9", pix_ready, 1);
      end

      // aborted partial frame, then a full frame restarted by start-of-frame
      build(0);
      send(3, 5, 1'b0);
      send(0, NP, 1'b0);
      collect(-1, 1'b0, mm);
      chk(mm == 0, "R6", mm, 0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule